// File: doc/BRIEF.md
# Reference-Period Frequency Multiplier

This block makes a faster clock-rate pulse train from a slow reference signal. It uses only the fast system clock and has no analog loop. It counts the system-clock cycles between two rising edges of the reference. The count is shifted right by a selectable amount, and the result is the interval, in cycles, between output pulses. Each reference period then holds 2^shift pulses. The interval counter restarts at every reference rising edge, so the pulse train stays tied to the reference period without a phase-error loop.

A second stage can scale the multiplied rate back down by a programmable fraction. It is a wide phase accumulator that adds the divider constant once per multiplied pulse. Its carry-out is the divided pulse. Each stage also drives a square wave that toggles on every pulse of that stage. The intended range is a reference below about 1 MHz against a system clock above about 24 MHz.

Top module: `ref_freq_mult`

## Requirements
- R1: The period is the number of system-clock cycles between two consecutive synchronized rising edges of `ref_in`. In steady state, consecutive `mul_pulse` assertions are `period >> shift_sel` cycles apart.
- R2: When the period is a multiple of 2^`shift_sel`, every window of one reference period in steady state holds exactly 2^`shift_sel` `mul_pulse` cycles.
- R3: A shifted period of zero is replaced by one, so `mul_pulse` is then high on every cycle.
- R4: After reset, no `mul_pulse` appears until two rising edges of the reference have been seen. The first edge only starts a measurement.
- R5: If the period counter reaches its all-ones value with no edge, the measurement is invalid and `mul_pulse` stops. The next edge only restarts the measurement, and pulses resume after the edge that follows it.
- R6: The interval value and `shift_sel` take effect only at a reference rising edge, where the interval counter also restarts from zero. A change of `shift_sel` within a period does not alter the pulse spacing until the next edge.
- R7: `mul_pulse` is a one-cycle strobe per interval. `mul_square` changes level in exactly the cycles in which `mul_pulse` is high.
- R8: On each `mul_pulse`, `div_step` is added to a DIV_W-bit accumulator. `div_pulse` is high for one cycle when that addition carries out, so its rate is the `mul_pulse` rate times `div_step` / 2^DIV_W. `div_square` toggles on each `div_pulse`, and a `div_step` of zero gives no `div_pulse`.
- R9: While `rst_n` is low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Slow reference, asynchronous to `clk` |
| shift_sel | input | SHIFT_W | Power-of-two multiplication exponent |
| div_step | input | DIV_W | Fractional divider constant |
| mul_pulse | output | 1 | One-cycle strobe at the multiplied rate |
| mul_square | output | 1 | Toggles on each `mul_pulse` |
| div_pulse | output | 1 | One-cycle strobe at the divided rate |
| div_square | output | 1 | Toggles on each `div_pulse` |

## Verification
The assertions assume that `ref_in` is slow compared with `clk`, so that each reference level lasts many cycles and the synchronizer never merges or skips an edge. They also assume that `shift_sel` and `div_step` are quasi-static between the points where the checks sample them. The stimulus makes every reference level last at least ten cycles. It changes `shift_sel` only right after a pulse and `div_step` only while waiting for the block to settle, before any measurement window.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  // Shifted period, clamped so the interval is never zero.
  function automatic int unsigned scale_period(input int unsigned period,
                                               input int unsigned sh);
    int unsigned q;
    q = period >> sh;
    return (q == 0) ? 1 : q;
  endfunction

  // Carry out of a width-limited unsigned add.
  function automatic bit add_carries(input longint unsigned a,
                                     input longint unsigned b,
                                     input int unsigned     w);
    longint unsigned s;
    s = a + b;
    return s[w];
  endfunction
endpackage

// File: rtl/fm_edge_sync.sv
`timescale 1ns/1ps
module fm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/fm_period_meter.sv
`timescale 1ns/1ps
module fm_period_meter #(
  parameter int CNT_W   = 16,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise,
  input  logic [SHIFT_W-1:0] shift_sel,
  output logic [CNT_W-1:0]   step,
  output logic               running,
  output logic               load,
  output logic               sat_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, sat_q;
  logic [CNT_W-1:0] step_d;

  assign step_d  = CNT_W'(fm_pkg::scale_period(32'(cnt_q), 32'(shift_sel)));
  assign load    = rise && armed_q && !sat_q;
  assign sat_evt = !rise && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      sat_q   <= 1'b0;
      running <= 1'b0;
      step    <= ONE;
    end else if (rise) begin
      cnt_q   <= ONE;
      armed_q <= 1'b1;
      sat_q   <= 1'b0;
      if (load) begin
        step    <= step_d;
        running <= 1'b1;
      end
    end else if (sat_evt) begin
      sat_q   <= 1'b1;
      running <= 1'b0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/fm_rate_accum.sv
`timescale 1ns/1ps
module fm_rate_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             load,
  input  logic [CNT_W-1:0] step,
  output logic             ovf,
  output logic             pulse,
  output logic             square
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] acc_q;

  assign ovf = running && ((acc_q + ONE) == step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pulse  <= 1'b0;
      square <= 1'b0;
    end else begin
      pulse  <= ovf;
      square <= square ^ ovf;
      if (load || ovf || !running) acc_q <= '0;
      else                         acc_q <= acc_q + ONE;
    end
  end
endmodule

// File: rtl/fm_frac_divider.sv
`timescale 1ns/1ps
module fm_frac_divider #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [DIV_W-1:0] step,
  output logic             pulse,
  output logic             square
);
  logic [DIV_W-1:0] acc_q;
  logic [DIV_W:0]   sum;
  logic             carry;

  assign sum   = {1'b0, acc_q} + {1'b0, step};
  assign carry = fm_pkg::add_carries(64'(acc_q), 64'(step), DIV_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pulse  <= 1'b0;
      square <= 1'b0;
    end else if (advance) begin
      acc_q  <= sum[DIV_W-1:0];
      pulse  <= carry;
      square <= square ^ carry;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_freq_mult.sv
`timescale 1ns/1ps
module ref_freq_mult #(
  parameter int CNT_W   = 16,
  parameter int SHIFT_W = 3,
  parameter int DIV_W   = 20,
  parameter bit DIV_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_in,
  input  logic [SHIFT_W-1:0] shift_sel,
  input  logic [DIV_W-1:0]   div_step,
  output logic               mul_pulse,
  output logic               mul_square,
  output logic               div_pulse,
  output logic               div_square
);
  // Internal events, named for the checker.
  logic             ref_rise_w;
  logic             load_w;
  logic             sat_w;
  logic             running_w;
  logic [CNT_W-1:0] step_w;
  logic             mul_ovf_w;

  fm_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise(ref_rise_w)
  );

  fm_period_meter #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(ref_rise_w), .shift_sel(shift_sel),
    .step(step_w), .running(running_w), .load(load_w), .sat_evt(sat_w)
  );

  fm_rate_accum #(.CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .running(running_w), .load(load_w),
    .step(step_w), .ovf(mul_ovf_w), .pulse(mul_pulse), .square(mul_square)
  );

  generate
    if (DIV_EN) begin : g_div
      fm_frac_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .advance(mul_pulse), .step(div_step),
        .pulse(div_pulse), .square(div_square)
      );
    end else begin : g_nodiv
      assign div_pulse  = 1'b0;
      assign div_square = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ref_freq_mult_chk.sv
`timescale 1ns/1ps
module ref_freq_mult_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             sat_evt,
  input logic             running,
  input logic [CNT_W-1:0] step,
  input logic             mul_pulse,
  input logic             mul_square,
  input logic             div_pulse
);
  // R7
  sq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_pulse |-> (mul_square != $past(mul_square)));
  // R7
  sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_pulse |-> $stable(mul_square));
  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !mul_pulse);
  // R3
  step_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (step != '0));
  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(step));
  // R5
  sat_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> !running);
  // R8
  div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(mul_pulse));
endmodule

bind ref_freq_mult ref_freq_mult_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_w), .sat_evt(sat_w),
  .running(running_w), .step(step_w), .mul_pulse(mul_pulse),
  .mul_square(mul_square), .div_pulse(div_pulse)
);

// File: tb/ref_freq_mult_bench.sv
`timescale 1ns/1ps
module ref_freq_mult_bench;
  localparam int CW = 12;
  localparam int SW = 3;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_in = 1'b0;
  logic [SW-1:0] shift_sel = '0;
  logic [DW-1:0] div_step = '0;
  logic          mul_pulse, mul_square, div_pulse, div_square;

  int  ref_period = 64;
  bit  ref_en = 1'b0;
  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  ref_freq_mult #(.CNT_W(CW), .SHIFT_W(SW), .DIV_W(DW)) u_ref_freq_mult (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .shift_sel(shift_sel),
    .div_step(div_step), .mul_pulse(mul_pulse), .mul_square(mul_square),
    .div_pulse(div_pulse), .div_square(div_square)
  );

  // Reference generator: one rising edge every ref_period cycles.
  initial begin
    forever begin
      if (ref_en) begin
        ref_in = 1'b1;
        repeat (ref_period / 2) @(negedge clk);
        ref_in = 1'b0;
        repeat (ref_period - ref_period / 2) @(negedge clk);
      end else begin
        ref_in = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(input int n, output int mp, output int mt,
                        output int dp, output int dt);
    bit pm, pd;
    mp = 0; mt = 0; dp = 0; dt = 0;
    pm = mul_square; pd = div_square;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mul_pulse) mp++;
      if (div_pulse) dp++;
      if (mul_square != pm) mt++;
      if (div_square != pd) dt++;
      pm = mul_square; pd = div_square;
    end
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (mul_pulse) break;
    end
  endtask

  task automatic interval(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (mul_pulse) break;
    end
  endtask

  // Stimulus/expectation table: period, shift, interval, pulses per period.
  localparam int NV = 6;
  localparam int V_P  [NV] = '{64, 64, 100, 48, 40, 20};
  localparam int V_S  [NV] = '{ 1,  3,   2,  0,  3,  6};
  localparam int V_K  [NV] = '{32,  8,  25, 48,  5,  1};
  localparam int V_N  [NV] = '{ 2,  8,   4,  1,  8, 20};

  initial begin
    int mp, mt, dp, dt, iv, prev_p;
    // R9: outputs low in reset
    repeat (5) @(negedge clk);
    check(!mul_pulse && !mul_square && !div_pulse && !div_square, "R9",
          {mul_pulse, mul_square, div_pulse, div_square}, 0);
    rst_n = 1'b1;

    // R4: first period after reset gives no pulses
    ref_period = 64; shift_sel = 3'd2; ref_en = 1'b1;
    window(60, mp, mt, dp, dt);
    check(mp == 0, "R4", mp, 0);

    prev_p = 64;
    for (int v = 0; v < NV; v++) begin
      ref_period = V_P[v];
      shift_sel  = SW'(V_S[v]);
      repeat (prev_p + 3 * V_P[v] + 10) @(negedge clk);
      wait_pulse();
      interval(iv);
      if (V_K[v] == 1) check(iv == V_K[v], "R3", iv, V_K[v]);
      else             check(iv == V_K[v], "R1", iv, V_K[v]);
      window(V_P[v], mp, mt, dp, dt);
      check(mp == V_N[v], "R2", mp, V_N[v]);
      check(mt == mp, "R7", mt, mp);
      prev_p = V_P[v];
    end

    // R6: shift change mid-period waits for the next edge
    ref_period = 64; shift_sel = 3'd0;
    repeat (20 + 4 * 64) @(negedge clk);
    wait_pulse();
    shift_sel = 3'd2;
    interval(iv);
    check(iv == 64, "R6", iv, 64);
    interval(iv);
    check(iv == 16, "R6", iv, 16);

    // R8: fractional divider
    shift_sel = 3'd3;
    repeat (3 * 64) @(negedge clk);
    div_step = DW'(1) << (DW - 1);
    repeat (64) @(negedge clk);
    window(64, mp, mt, dp, dt);
    check(mp == 8, "R2", mp, 8);
    check(dp == 4, "R8", dp, 4);
    check(dt == dp, "R8", dt, dp);
    div_step = DW'(1) << (DW - 2);
    repeat (64) @(negedge clk);
    window(64, mp, mt, dp, dt);
    check(dp == 2, "R8", dp, 2);
    div_step = '0;
    repeat (64) @(negedge clk);
    window(64, mp, mt, dp, dt);
    check(dp == 0, "R8", dp, 0);

    // R5: reference stops, counter saturates, pulses stop
    ref_en = 1'b0;
    repeat ((1 << CW) + 200) @(negedge clk);
    window(200, mp, mt, dp, dt);
    check(mp == 0, "R5", mp, 0);
    ref_en = 1'b1;
    window(60, mp, mt, dp, dt);
    check(mp == 0, "R5", mp, 0);
    repeat (3 * 64) @(negedge clk);
    window(64, mp, mt, dp, dt);
    check(mp == 8, "R5", mp, 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5.0);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule